// File: doc/BRIEF.md
# Serial Bit-Rate Divider

This block derives the timing for an asynchronous serial port from the bus clock. The bus clock is the CPU clock divided by four. It reaches the block as a one-cycle enable, `bus_en`, in the system clock domain. A byte-wide configuration register selects a non-power-of-two prescale factor and a power-of-two rate multiplier. From these the block produces two single-cycle pulses: `tick16`, the 16x oversampling strobe, and `tick_bit`, which marks one full bit period. The complete bus-clock divisor per bit is also driven out for software readback.

The register is loaded through a simple write strobe. The written value can always be read back on `cfg_q`. Writing a value restarts every internal counter, so the old setting leaves no partial period behind. A synchronous reset clears the register to zero. When `boot_mode` is held high during reset, the register is instead preset to a value that gives roughly 1200 baud from a 2 MHz bus clock. Two test bits are stored and read back but drive nothing. Framing and data handling belong to the neighbouring transmitter and receiver.

Top module: `sci_baud_div`

## Requirements
- R1: Configuration bits 5:4 select the prescale factor: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R2: `divisor` equals prescale factor × 16 × 2^rate, where rate is configuration bits 2:0.
- R3: `tick16` pulses once for every (prescale factor × 2^rate) cycles with `bus_en` high. The pulse appears in the cycle after the edge that completes the count. No pulse appears while `bus_en` stays low.
- R4: `tick_bit` is high together with every sixteenth `tick16` pulse after a restart, and at no other time.
- R5: `cfg_q` returns the last written byte with bit 6 forced to 0.
- R6: Bits 7 and 3 are stored and read back, but they change neither `divisor` nor the tick timing.
- R7: While `rst_n` is low with `boot_mode` low, `cfg_q` becomes 0x00 (divisor 16), and both ticks stay low.
- R8: When reset is taken with `boot_mode` high, `cfg_q` becomes 0x33. This gives a divisor of 1664 and a `tick16` every 104 enabled cycles.
- R9: A write clears all counters. A `bus_en` in the same cycle as the write is not counted, no tick appears in the cycle after the write, and the first `tick16` comes exactly one full oversampling period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 1 | Selects the boot preset as the reset value |
| bus_en | input | 1 | One-cycle bus-clock enable (CPU clock / 4) |
| wr_en | input | 1 | Write strobe for the configuration register |
| wr_data | input | 8 | Value to write |
| cfg_q | output | 8 | Configuration readback, bit 6 always 0 |
| divisor | output | 15 | Bus clocks per serial bit |
| tick16 | output | 1 | Oversampling pulse, 16 per bit |
| tick_bit | output | 1 | One pulse per bit period |

## Verification
The bench builds the block with its defaults: 16x oversampling and the 0x33 boot preset. With these settings every prescale code and the extreme rate codes 0 and 7 can be timed pulse by pulse. When the enable runs every cycle, even the slowest setting of 1664 enabled cycles per sample completes two full periods. Settings with short periods use a one-in-four enable, so that a count of enabled cycles is kept apart from a count of clock cycles. Those settings run for seventeen samples, which reaches the bit tick.

// File: rtl/sci_div_pkg.sv
// Package: shared constants and helpers for the serial bit-rate divider.
// Assumes the fixed byte layout: bit 7 test clear, bits 5:4 prescale,
// bit 3 clock check, bits 2:0 rate select, bit 6 unimplemented.
package sci_div_pkg;
    localparam int CFG_W    = 8;
    localparam int PRE_LSB  = 4;
    localparam int PRE_W    = 2;
    localparam int RATE_LSB = 0;
    localparam int RATE_W   = 3;
    localparam int FACT_W   = 4;                        // holds factor up to 13
    localparam int RCNT_W   = (1 << RATE_W) - 1;        // counts up to 2^7
    localparam logic [CFG_W-1:0] CFG_KEEP = 8'hBF;      // bit 6 never stored

    // Map the prescale code to its divide factor; anything unmatched is 13.
    function automatic logic [FACT_W-1:0] presc_factor(input logic [PRE_W-1:0] code);
        case (code)
            2'b00:   presc_factor = 4'd1;
            2'b01:   presc_factor = 4'd3;
            2'b10:   presc_factor = 4'd4;
            default: presc_factor = 4'd13;
        endcase
    endfunction
endpackage

// File: rtl/sci_div_cfg.sv
// Configuration register. Holds the byte written by wr_en, with bit 6 dropped.
// Assumes a synchronous active-low reset; boot_mode picks the reset value.
module sci_div_cfg
    import sci_div_pkg::*;
#(
    parameter logic [CFG_W-1:0] BOOT_CFG = 8'h33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_mode,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q
);
    localparam logic [CFG_W-1:0] BOOT_VAL = BOOT_CFG & CFG_KEEP;

    // Store a write or the selected reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= boot_mode ? BOOT_VAL : '0;
        else if (wr_en)
            cfg_q <= wr_data & CFG_KEEP;
    end
endmodule

// File: rtl/sci_div_presc.sv
// Prescale stage. Counts bus_en pulses modulo the selected factor and raises
// step on the pulse that completes a cycle. Assumes the code only changes
// together with restart.
module sci_div_presc
    import sci_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             bus_en,
    input  logic [PRE_W-1:0] code,
    output logic             step
);
    logic [FACT_W-1:0] cnt;
    logic [FACT_W-1:0] last_val;
    logic              at_last;

    // Decode the terminal count from the selected factor.
    always_comb begin
        last_val = presc_factor(code) - FACT_W'(1);
        at_last  = (cnt == last_val);
    end

    // Advance on each enabled bus clock; restart and reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (bus_en)
            cnt <= at_last ? '0 : cnt + FACT_W'(1);
    end

    assign step = bus_en && !restart && at_last;
endmodule

// File: rtl/sci_div_rate.sv
// Rate stage. Counts prescale steps modulo 2^rate and raises os_evt when a
// full oversampling period is complete. Assumes step is already gated by
// restart.
module sci_div_rate
    import sci_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [RATE_W-1:0] rate,
    output logic              os_evt
);
    logic [RCNT_W-1:0] cnt;
    logic [RCNT_W:0]   lim;
    logic              at_last;

    // Terminal value 2^rate - 1, one bit wider so rate 7 does not wrap.
    always_comb begin
        lim     = ((RCNT_W + 1)'(1) << rate) - (RCNT_W + 1)'(1);
        at_last = ({1'b0, cnt} == lim);
    end

    // Advance once per prescale step.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (step)
            cnt <= at_last ? '0 : cnt + RCNT_W'(1);
    end

    assign os_evt = step && at_last;
endmodule

// File: rtl/sci_div_bitcnt.sv
// Bit stage. Counts oversampling events modulo 2^OS_LOG2 and flags the
// event that closes a bit period.
module sci_div_bitcnt #(
    parameter int OS_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic os_evt,
    output logic bit_evt
);
    logic [OS_LOG2-1:0] cnt;

    // Count oversampling events since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (os_evt)
            cnt <= cnt + OS_LOG2'(1);
    end

    assign bit_evt = os_evt && (&cnt);
endmodule

// File: rtl/sci_baud_div.sv
// Serial bit-rate divider top. Chains prescale, rate and bit stages, and
// registers the two tick pulses. Assumes bus_en is high for single cycles
// at the bus-clock rate; ticks follow one cycle after the enabling edge.
module sci_baud_div
    import sci_div_pkg::*;
#(
    parameter int               OS_LOG2  = 4,
    parameter logic [CFG_W-1:0] BOOT_CFG = 8'h33,
    localparam int              DIV_W    = FACT_W + OS_LOG2 + RCNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_mode,
    input  logic             bus_en,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output logic [DIV_W-1:0] divisor,
    output logic             tick16,
    output logic             tick_bit
);
    logic [PRE_W-1:0]  pre_code;
    logic [RATE_W-1:0] rate_code;
    logic              step;
    logic              os_evt;
    logic              bit_evt;

    sci_div_cfg #(.BOOT_CFG(BOOT_CFG)) cfg_i (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q)
    );

    assign pre_code  = cfg_q[PRE_LSB +: PRE_W];
    assign rate_code = cfg_q[RATE_LSB +: RATE_W];

    sci_div_presc presc_i (
        .clk(clk), .rst_n(rst_n), .restart(wr_en), .bus_en(bus_en),
        .code(pre_code), .step(step)
    );

    sci_div_rate rate_i (
        .clk(clk), .rst_n(rst_n), .restart(wr_en), .step(step),
        .rate(rate_code), .os_evt(os_evt)
    );

    sci_div_bitcnt #(.OS_LOG2(OS_LOG2)) bitc_i (
        .clk(clk), .rst_n(rst_n), .restart(wr_en), .os_evt(os_evt),
        .bit_evt(bit_evt)
    );

    // Total bus clocks per bit for readback.
    always_comb begin
        divisor = (DIV_W'(presc_factor(pre_code)) << OS_LOG2) << rate_code;
    end

    // Register the tick pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick16   <= 1'b0;
            tick_bit <= 1'b0;
        end else begin
            tick16   <= os_evt;
            tick_bit <= bit_evt;
        end
    end
endmodule

// File: rtl/sci_baud_div_chk.sv
// Checker for the serial bit-rate divider, attached by bind.
module sci_baud_div_chk #(
    parameter int OS_LOG2 = 4,
    parameter int DIV_W   = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [7:0]       cfg_q,
    input logic [DIV_W-1:0] divisor,
    input logic             tick16,
    input logic             tick_bit
);
    AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (!rst_n)
        tick_bit |-> tick16);                                             // R4
    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |-> ($past(bus_en) && !$past(wr_en)));                     // R3
    AST_NO_TICK_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!tick16 && !tick_bit));                                // R9
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == ($past(wr_data) & 8'hBF)));                   // R5
    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));                                       // R5
    AST_DIV_MULT_OS: assert property (@(posedge clk) disable iff (!rst_n)
        divisor[OS_LOG2-1:0] == '0);                                      // R2
endmodule

bind sci_baud_div sci_baud_div_chk #(.OS_LOG2(OS_LOG2), .DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .wr_en(wr_en),
    .wr_data(wr_data), .cfg_q(cfg_q), .divisor(divisor),
    .tick16(tick16), .tick_bit(tick_bit)
);

// File: tb/sci_baud_div_tb_top.sv
// Bench for the serial bit-rate divider: a vector table walked by one loop,
// then directed reset and corner tests.
module sci_baud_div_tb_top;
    localparam int DW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          boot_mode = 1'b0;
    logic          bus_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    cfg_q;
    logic [DW-1:0] divisor;
    logic          tick16;
    logic          tick_bit;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sci_baud_div dut_i (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .bus_en(bus_en),
        .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q), .divisor(divisor),
        .tick16(tick16), .tick_bit(tick_bit)
    );

    // cfg, expected divisor, expected samples period, enable gap, samples
    localparam int NV = 8;
    localparam int unsigned VEC [NV][5] = '{
        '{32'h00,    16,    1, 4, 17},
        '{32'h10,    48,    3, 4, 17},
        '{32'h21,   128,    8, 4, 17},
        '{32'h32,   832,   52, 1, 17},
        '{32'h07,  2048,  128, 1, 3},
        '{32'h37, 26624, 1664, 1, 2},
        '{32'hC9,    32,    2, 4, 17},
        '{32'h1B,   384,   24, 4, 17}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Time nos oversampling periods from a restart with a given enable gap.
    task automatic measure(input int p, input int nos, input int gap, input string first_req);
        int cnt = 0;
        int seen = 0;
        int os = 0;
        int limit = nos * p * gap + 64;
        for (int cyc = 0; cyc < limit && seen < nos; cyc++) begin
            bit drv;
            drv = (gap == 1) || ((cyc % gap) == gap - 1);
            bus_en = drv;
            @(negedge clk);
            if (drv) cnt++;
            if (tick16) begin
                check(cnt == p, (seen == 0) ? first_req : "R3 period", cnt, p);
                cnt = 0;
                seen++;
                os++;
                if (os == 16) begin
                    check(tick_bit == 1'b1, "R4 bit tick on 16th", int'(tick_bit), 1);
                    os = 0;
                end else begin
                    check(tick_bit == 1'b0, "R4 no early bit tick", int'(tick_bit), 0);
                end
            end else if (tick_bit) begin
                check(1'b0, "R4 bit tick without sample tick", 1, 0);
            end
        end
        bus_en = 1'b0;
        check(seen == nos, "R3 sample ticks seen", seen, nos);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        bus_en  = 1'b1;          // coincident enable must not be counted (R9)
        @(negedge clk);
        wr_en  = 1'b0;
        bus_en = 1'b0;
        check(!tick16 && !tick_bit, "R9 no tick after write", int'(tick16), 0);
    endtask

    task automatic do_reset(input bit boot);
        boot_mode = boot;
        rst_n  = 1'b0;
        bus_en = 1'b0;
        wr_en  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        // R7: plain reset value
        do_reset(1'b0);
        check(cfg_q == 8'h00, "R7 reset cfg", cfg_q, 0);
        check(divisor == 16, "R7 reset divisor", divisor, 16);
        check(!tick16 && !tick_bit, "R7 ticks low in reset", int'(tick16), 0);
        rst_n = 1'b1;
        measure(1, 17, 4, "R7 period after reset");

        // Table: R1 R2 R5 R6 R9 R3 R4
        for (int i = 0; i < NV; i++) begin
            logic [7:0] c;
            c = VEC[i][0][7:0];
            write_cfg(c);
            check(cfg_q == (c & 8'hBF), "R5 readback", cfg_q, c & 8'hBF);
            check(divisor == VEC[i][1], (c & 8'h88) != 0 ? "R6 divisor with test bits" : "R1 R2 divisor",
                  divisor, VEC[i][1]);
            measure(VEC[i][2], VEC[i][4], VEC[i][3], (c & 8'h88) != 0 ? "R6 first period" : "R9 first period");
        end

        // R3: no enable, no tick
        write_cfg(8'h00);
        begin
            int hits = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (tick16 || tick_bit) hits++;
            end
            check(hits == 0, "R3 no tick without enable", hits, 0);
        end

        // R9: rewrite in mid-period restarts the count
        write_cfg(8'h21);
        measure(8, 1, 4, "R9 first period");
        bus_en = 1'b1; @(negedge clk); bus_en = 1'b0; @(negedge clk);
        bus_en = 1'b1; @(negedge clk); bus_en = 1'b0;
        write_cfg(8'h21);
        measure(8, 2, 4, "R9 period after mid rewrite");

        // R8: boot preset
        do_reset(1'b1);
        check(cfg_q == 8'h33, "R8 boot cfg", cfg_q, 8'h33);
        check(divisor == 1664, "R8 boot divisor", divisor, 1664);
        rst_n = 1'b1;
        measure(104, 17, 1, "R8 boot period");

        done = 1'b1;
        finish_run();
    end
endmodule